// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral interface master that a processor drives through a small bank of 32-bit registers. Software picks the frame format in a control word: clock idle level, sampling phase, bit order, word length (4 to 16 bits, or 32 bits), bit-rate prescaler and an optional internal loopback. A write to the transmit register starts one word exchange. The block drives the serial clock and data-out lines, samples data-in, and places the received word in the receive register.

A completed word raises a receive-ready event. A transmit-free event is low while the shifter is busy and high again once it is idle. Both events are cleared by writing ones. An interrupt line is the OR of the events the mask register allows.

An alternate alignment mode lets software use short words in the upper half of the data registers, which suits hosts that move 8- or 16-bit data in the high bytes of a 32-bit word. Software is expected to clear the enable bit before it reprograms the format.

Top module: `spim_regbank`

## Requirements
- R1: After reset every register reads zero, the serial clock and data-out lines are low and the interrupt is low.
- R2: The control word (byte offset 0x20), mask (0x28, bits 9 and 8 only) and command (0x2C) registers read back what was written. The transmit register (0x30) reads back the last word that was accepted. Events sit at 0x24 and the received word at 0x34.
- R3: Control bits 23:20 hold the word length minus one, and the value 0 selects 32 bits. The received word holds exactly that many bits, right-justified, with all higher bits zero.
- R4: The serial clock period is 4×(P+1) input clocks, where P is control bits 19:16. When control bit 27 is set the period is 64×(P+1) input clocks.
- R5: Control bit 29 sets the serial clock idle level, and the clock returns to that level after each word. Control bit 28 set means data is launched on the leading clock edge and sampled on the trailing edge; clear means data is sampled on the leading edge.
- R6: Control bit 26 set sends and receives the most significant bit first; clear means least significant bit first.
- R7: With control bit 30 set, the transmitted bits feed the receiver internally and the external data-out line stays low.
- R8: When a word completes, event bit 9 (receive ready) and event bit 8 (transmit free) are set. Event bit 8 reads low for the whole time a word is shifting.
- R9: Writing a one to an event bit clears it. Writing a zero leaves it unchanged.
- R10: The interrupt output is high exactly when some event bit is set whose mask bit is set.
- R11: With control bit 14 set and MSB-first order, an 8-bit word is sent from transmit bits 31:24 and returned in receive bits 23:16, and a 16-bit word uses bits 31:16 both ways. With LSB-first order, transmit data is taken from bit 0, an 8-bit word is returned in bits 15:8, and a 16-bit word is returned at bit 0. 32-bit words are unaffected.
- R12: A transmit write while a word is shifting is ignored: the transmit register and the word in flight do not change.
- R13: A transmit write starts a word only when control bits 24 (enable) and 25 (master) are both set. Clearing enable mid-word abandons the word: the clock goes to idle, no receive event is raised, and transmit free is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. The divider's half-period ticks never come back to back. The edge counter stays inside the programmed word. The clock is back at its idle level when a word ends. Clearing enable ends a shift. A completed word sets receive ready, transmit free stays low while busy, a write of one clears receive ready, and a transmit write during a shift leaves the transmit register as it was. Only the bench scenarios can show the other behaviours: the received value for each length, order, phase and alignment combination, the bit order seen on the wire by an external slave, the measured clock periods, the hold of data-out in loopback, and the interrupt under each mask setting.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 4;
  localparam int PM_W   = 4;
  localparam int NB_W   = $clog2(DATA_W) + 1;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_MODE = 8'h20;
  localparam logic [ADDR_W-1:0] A_EVT  = 8'h24;
  localparam logic [ADDR_W-1:0] A_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] A_CMD  = 8'h2C;
  localparam logic [ADDR_W-1:0] A_TXD  = 8'h30;
  localparam logic [ADDR_W-1:0] A_RXD  = 8'h34;

  localparam int B_LOOP  = 30;
  localparam int B_CPOL  = 29;
  localparam int B_CPHA  = 28;
  localparam int B_DIV16 = 27;
  localparam int B_MSB   = 26;
  localparam int B_MSTR  = 25;
  localparam int B_EN    = 24;
  localparam int B_LEN   = 20;
  localparam int B_PM    = 16;
  localparam int B_ALT   = 14;
  localparam int B_NE    = 9;
  localparam int B_NF    = 8;

  typedef struct packed {
    logic             loop;
    logic             cpol;
    logic             cpha;
    logic             div16;
    logic             msb;
    logic             master;
    logic             en;
    logic [LEN_W-1:0] len;
    logic [PM_W-1:0]  pm;
    logic             alt;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [DATA_W-1:0] r);
    ctl_t c;
    c.loop   = r[B_LOOP];
    c.cpol   = r[B_CPOL];
    c.cpha   = r[B_CPHA];
    c.div16  = r[B_DIV16];
    c.msb    = r[B_MSB];
    c.master = r[B_MSTR];
    c.en     = r[B_EN];
    c.len    = r[B_LEN +: LEN_W];
    c.pm     = r[B_PM +: PM_W];
    c.alt    = r[B_ALT];
    return c;
  endfunction

  function automatic logic [NB_W-1:0] word_bits(input logic [LEN_W-1:0] len);
    return (len == '0) ? NB_W'(DATA_W) : NB_W'(len) + NB_W'(1);
  endfunction

  function automatic logic [NB_W-1:0] tx_shift(input logic [NB_W-1:0] nb,
                                                input logic alt, input logic msb);
    if (!alt || !msb)        return '0;
    else if (nb <= NB_W'(8))  return NB_W'(24);
    else if (nb <= NB_W'(16)) return NB_W'(16);
    else                      return '0;
  endfunction

  function automatic logic [NB_W-1:0] rx_shift(input logic [NB_W-1:0] nb,
                                                input logic alt, input logic msb);
    if (!alt)                 return '0;
    else if (nb <= NB_W'(8))  return msb ? NB_W'(16) : NB_W'(8);
    else if (nb <= NB_W'(16)) return msb ? NB_W'(16) : NB_W'(0);
    else                      return '0;
  endfunction
endpackage

// File: rtl/spim_divider.sv
module spim_divider
  import spim_pkg::*;
#(
  parameter int PMW = PM_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           div16,
  input  logic [PMW-1:0] pm,
  output logic           tick
);
  localparam int CW = PMW + 6;

  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = CW'((32'(pm) + 32'd1) << (div16 ? 5 : 1));
    tick  = run && (cnt_q == limit - CW'(1));
    cnt_d = (!run || tick) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: a half period is at least two input clocks
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int NBW = NB_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           start,
  input  logic [DW-1:0]  load_word,
  input  logic [NBW-1:0] nbits,
  input  logic           cpol,
  input  logic           cpha,
  input  logic           msb,
  input  logic           loop,
  input  logic           miso,
  input  logic           tick,
  output logic           busy,
  output logic           done,
  output logic           sck,
  output logic           mosi,
  output logic [DW-1:0]  rx_word
);
  localparam int IW = $clog2(DW);

  logic           busy_q, busy_d, sck_q, sck_d, mosi_q, mosi_d, done_q, done_d;
  logic [NBW:0]   ecnt_q, ecnt_d;
  logic [DW-1:0]  word_q, word_d, rx_q, rx_d;
  logic [NBW-1:0] bidx, pos0, pos_cur, pos_nxt;
  logic           last, rx_in;

  function automatic logic [NBW-1:0] bitpos(input logic [NBW-1:0] b);
    return msb ? (nbits - NBW'(1) - b) : b;
  endfunction

  always_comb begin
    bidx    = ecnt_q[NBW:1];
    pos0    = bitpos('0);
    pos_cur = bitpos(bidx);
    pos_nxt = bitpos(bidx + NBW'(1));
    last    = (ecnt_q == ({nbits, 1'b0} - (NBW+1)'(1)));
    rx_in   = loop ? mosi_q : miso;

    busy_d = busy_q;
    sck_d  = sck_q;
    mosi_d = mosi_q;
    done_d = 1'b0;
    ecnt_d = ecnt_q;
    word_d = word_q;
    rx_d   = rx_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        ecnt_d = '0;
        sck_d  = cpol;
        word_d = load_word;
        rx_d   = '0;
        mosi_d = cpha ? 1'b0 : load_word[pos0[IW-1:0]];
      end
    end else if (!en) begin
      busy_d = 1'b0;
    end else if (tick) begin
      sck_d  = ~sck_q;
      ecnt_d = ecnt_q + (NBW+1)'(1);
      if (ecnt_q[0] == cpha)
        rx_d[pos_cur[IW-1:0]] = rx_in;
      if (cpha && !ecnt_q[0])
        mosi_d = word_q[pos_cur[IW-1:0]];
      if (!cpha && ecnt_q[0] && !last)
        mosi_d = word_q[pos_nxt[IW-1:0]];
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      ecnt_q <= '0;
      word_q <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
      ecnt_q <= ecnt_d;
      word_q <= word_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign sck     = (busy_q && en) ? sck_q : cpol;
  assign mosi    = (busy_q && en && !loop) ? mosi_q : 1'b0;
  assign rx_word = rx_q;

  // R3: the edge count never runs past the programmed word
  p_edge_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ecnt_q < {nbits, 1'b0}));

  // R5: the clock is back at its idle level when a word ends
  p_idle_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && en && tick && last) |=> (!busy_q && sck_q == $past(cpol)));

  // R13: clearing enable ends a shift
  p_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !en) |=> !busy_q);
endmodule

// File: rtl/spim_regbank.sv
module spim_regbank
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              irq
);
  logic [DATA_W-1:0] ctl_q, ctl_d, cmd_q, cmd_d, tx_q, tx_d, rx_q, rx_d;
  logic [1:0]        ev_q, ev_d, msk_q, msk_d;
  ctl_t              c;
  logic [NB_W-1:0]   nbits;
  logic              wr_ctl, wr_evt, wr_msk, wr_cmd, wr_txd;
  logic              start, abort, tick;
  logic              eng_busy, eng_done;
  logic [DATA_W-1:0] eng_rx, load_word;

  always_comb begin
    c         = decode_ctl(ctl_q);
    nbits     = word_bits(c.len);
    wr_ctl    = bus_wr && (bus_addr == A_MODE);
    wr_evt    = bus_wr && (bus_addr == A_EVT);
    wr_msk    = bus_wr && (bus_addr == A_MASK);
    wr_cmd    = bus_wr && (bus_addr == A_CMD);
    wr_txd    = bus_wr && (bus_addr == A_TXD);
    start     = wr_txd && c.en && c.master && !eng_busy;
    abort     = eng_busy && !c.en;
    load_word = bus_wdata >> tx_shift(nbits, c.alt, c.msb);

    ctl_d = wr_ctl ? bus_wdata : ctl_q;
    cmd_d = wr_cmd ? bus_wdata : cmd_q;
    msk_d = wr_msk ? bus_wdata[B_NE:B_NF] : msk_q;
    tx_d  = start ? bus_wdata : tx_q;
    rx_d  = eng_done ? (eng_rx << rx_shift(nbits, c.alt, c.msb)) : rx_q;

    ev_d = ev_q;
    if (wr_evt)   ev_d = ev_q & ~bus_wdata[B_NE:B_NF];
    if (eng_done) ev_d = 2'b11;
    if (abort)    ev_d[0] = 1'b1;
    if (start)    ev_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmd_q <= '0;
      msk_q <= '0;
      ev_q  <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      cmd_q <= cmd_d;
      msk_q <= msk_d;
      ev_q  <= ev_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata = ctl_q;
      A_EVT:   bus_rdata[B_NE:B_NF] = ev_q;
      A_MASK:  bus_rdata[B_NE:B_NF] = msk_q;
      A_CMD:   bus_rdata = cmd_q;
      A_TXD:   bus_rdata = tx_q;
      A_RXD:   bus_rdata = rx_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(ev_q & msk_q);

  spim_divider #(.PMW(PM_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (eng_busy && c.en),
    .div16 (c.div16),
    .pm    (c.pm),
    .tick  (tick)
  );

  spim_shifter #(.DW(DATA_W), .NBW(NB_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (c.en),
    .start     (start),
    .load_word (load_word),
    .nbits     (nbits),
    .cpol      (c.cpol),
    .cpha      (c.cpha),
    .msb       (c.msb),
    .loop      (c.loop),
    .miso      (spi_miso),
    .tick      (tick),
    .busy      (eng_busy),
    .done      (eng_done),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .rx_word   (eng_rx)
  );

  // R8: a finished word always raises receive ready
  p_ne_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> ev_q[1]);

  // R8: transmit free stays low while the shifter runs
  p_nf_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !ev_q[0]);

  // R9: a one written to receive ready clears it
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_wdata[B_NE] && !eng_done) |=> !ev_q[1]);

  // R12: a transmit write during a shift leaves the register alone
  p_busy_wr_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && eng_busy) |=> $stable(tx_q));
endmodule

// File: tb/tb_spim_regbank.sv
module tb_spim_regbank;
  localparam int NV = 13;
  localparam logic [31:0] V_MODE [NV] = '{
    32'h4770_0000, 32'h7370_0000, 32'h5730_0000, 32'h67F0_0000,
    32'h4300_0000, 32'h57B0_0000, 32'h4770_4000, 32'h47F0_4000,
    32'h4370_4000, 32'h63F0_4000, 32'h4700_4000, 32'h4F70_0000,
    32'h7772_0000};
  localparam logic [31:0] V_TX [NV] = '{
    32'h0000_00A5, 32'h1234_5C3C, 32'hFFFF_FFF9, 32'hABCD_1234,
    32'hDEAD_BEEF, 32'h5A5A_5A5A, 32'hC312_3456, 32'hBEEF_1111,
    32'hAB00_0071, 32'h9999_4321, 32'h0102_0304, 32'h0000_005A,
    32'h0000_0081};
  localparam logic [31:0] V_RX [NV] = '{
    32'h0000_00A5, 32'h0000_003C, 32'h0000_0009, 32'h0000_1234,
    32'hDEAD_BEEF, 32'h0000_0A5A, 32'h00C3_0000, 32'hBEEF_0000,
    32'h0000_7100, 32'h0000_4321, 32'h0102_0304, 32'h0000_005A,
    32'h0000_0081};
  localparam logic [7:0] PAT = 8'h96;

  logic        clk, rst_n, bus_wr, spi_miso;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sck, spi_mosi, irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] rise_cnt = 8'd0;
  logic [7:0] ext_base = 8'd0;
  logic [7:0] cap = 8'd0;
  logic [2:0] ridx;
  logic       in_loop = 1'b0;
  logic       mosi_leak = 1'b0;

  spim_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq));

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  // external slave: launches PAT MSB first, captures data-out on rising clock
  assign ridx = 3'd7 - 3'(rise_cnt - ext_base);
  assign spi_miso = PAT[ridx];
  always @(posedge spi_sck) begin
    rise_cnt <= rise_cnt + 8'd1;
    cap      <= {cap[6:0], spi_mosi};
  end
  always @(posedge clk) if (in_loop && spi_mosi) mosi_leak <= 1'b1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_ne(input string tag);
    logic [31:0] e;
    for (int k = 0; k < 6000; k++) begin
      rd(8'h24, e);
      if (e[9]) return;
    end
    check({tag, " receive ready timeout"}, 32'h0, 32'h200);
  endtask

  task automatic xfer(input logic [31:0] mode, input logic [31:0] tx,
                      input string tag, output logic [31:0] rx);
    wr(8'h20, mode & ~32'h0100_0000);
    wr(8'h20, mode);
    wr(8'h24, 32'h300);
    wr(8'h30, tx);
    wait_ne(tag);
    rd(8'h34, rx);
  endtask

  task automatic period(input logic [31:0] mode, input string tag, input int exp);
    int t0;
    logic [31:0] r;
    wr(8'h20, mode & ~32'h0100_0000);
    wr(8'h20, mode);
    wr(8'h24, 32'h300);
    wr(8'h30, 32'h0000_00C3);
    @(posedge spi_sck); t0 = cyc;
    @(posedge spi_sck);
    check(tag, 32'(cyc - t0), 32'(exp));
    wait_ne(tag);
    rd(8'h34, r);
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h20, r); check("R1 mode", r, 0);
    rd(8'h24, r); check("R1 events", r, 0);
    rd(8'h28, r); check("R1 mask", r, 0);
    rd(8'h2C, r); check("R1 command", r, 0);
    rd(8'h30, r); check("R1 transmit", r, 0);
    rd(8'h34, r); check("R1 receive", r, 0);
    check("R1 pins", {29'h0, spi_sck, spi_mosi, irq}, 0);

    // R2: read back
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, r); check("R2 mask", r, 32'h300);
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h55AA_00FF); rd(8'h2C, r); check("R2 command", r, 32'h55AA_00FF);
    wr(8'h20, 32'h0012_3400); rd(8'h20, r); check("R2 mode", r, 32'h0012_3400);

    // R6: order on the wire, external slave
    ext_base = rise_cnt;
    xfer(32'h0770_0000, 32'h01, "R6 msb", r);
    check("R6 msb received", r, 32'h96);
    check("R6 msb on wire", {24'h0, cap}, 32'h01);
    xfer(32'h0370_0000, 32'h01, "R6 lsb", r);
    check("R6 lsb received", r, 32'h69);
    check("R6 lsb on wire", {24'h0, cap}, 32'h80);
    check("R7 data-out idle after word", {31'h0, spi_mosi}, 0);

    // R3/R5/R6/R11: loopback vector table
    in_loop = 1'b1;
    for (int i = 0; i < NV; i++) begin
      xfer(V_MODE[i], V_TX[i], "R3 R11 vector", r);
      check($sformatf("R3/R5/R11 vector %0d", i), r, V_RX[i]);
    end
    in_loop = 1'b0;
    check("R7 data-out held low in loopback", {31'h0, mosi_leak}, 0);

    // R8: transmit free low while busy, both events after
    wr(8'h20, 32'h4670_0000); wr(8'h20, 32'h4770_0000);
    wr(8'h24, 32'h300);
    wr(8'h30, 32'h0000_0011);
    rd(8'h24, r); check("R8 events while busy", r, 0);
    wait_ne("R8");
    rd(8'h24, r); check("R8 events after word", r, 32'h300);

    // R10: interrupt versus mask
    wr(8'h28, 32'h0);   check("R10 masked off", {31'h0, irq}, 0);
    wr(8'h28, 32'h200); check("R10 receive ready mask", {31'h0, irq}, 1);

    // R9: write-one-to-clear
    wr(8'h24, 32'h200); rd(8'h24, r); check("R9 clear receive ready", r, 32'h100);
    check("R10 cleared source", {31'h0, irq}, 0);
    wr(8'h28, 32'h100); check("R10 transmit free mask", {31'h0, irq}, 1);
    wr(8'h24, 32'h0);   rd(8'h24, r); check("R9 zero write keeps", r, 32'h100);
    wr(8'h24, 32'h100); rd(8'h24, r); check("R9 clear transmit free", r, 0);
    check("R10 all clear", {31'h0, irq}, 0);
    wr(8'h28, 32'h0);

    // R4: bit rate
    period(32'h4772_0000, "R4 plain prescale", 12);
    period(32'h4F71_0000, "R4 divide by 16", 128);

    // R5: idle high clock
    wr(8'h20, 32'h6670_0000); wr(8'h20, 32'h6770_0000);
    check("R5 idle high", {31'h0, spi_sck}, 1);
    xfer(32'h6770_0000, 32'h0000_00E7, "R5", r);
    check("R5 cpol1 data", r, 32'hE7);
    check("R5 idle high after word", {31'h0, spi_sck}, 1);

    // R12: write during shift ignored
    wr(8'h20, 32'h4670_0000); wr(8'h20, 32'h4770_0000);
    wr(8'h24, 32'h300);
    wr(8'h30, 32'h0000_003C);
    repeat (5) @(negedge clk);
    wr(8'h30, 32'h0000_00FF);
    wait_ne("R12");
    rd(8'h30, r); check("R12 transmit kept", r, 32'h3C);
    rd(8'h34, r); check("R12 word in flight kept", r, 32'h3C);

    // R13: abort and start conditions
    wr(8'h20, 32'h4E73_0000); wr(8'h20, 32'h4F73_0000);
    wr(8'h24, 32'h300);
    wr(8'h30, 32'h0000_005A);
    repeat (300) @(negedge clk);
    wr(8'h20, 32'h4E73_0000);
    repeat (2) @(negedge clk);
    check("R13 clock idle after abort", {31'h0, spi_sck}, 0);
    repeat (2500) @(negedge clk);
    rd(8'h24, r); check("R13 abort events", r, 32'h100);
    wr(8'h30, 32'h0000_0077);
    repeat (600) @(negedge clk);
    rd(8'h30, r); check("R13 disabled write dropped", r, 32'h5A);
    rd(8'h24, r); check("R13 disabled no word", r, 32'h100);
    wr(8'h20, 32'h4D73_0000);
    wr(8'h24, 32'h300);
    wr(8'h30, 32'h0000_0011);
    repeat (300) @(negedge clk);
    rd(8'h24, r); check("R13 no master no word", r, 0);
    rd(8'h30, r); check("R13 no master write dropped", r, 32'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule